// File: doc/BRIEF.md
# Two-Wire Bus Timing Monitor

This block watches the clock and data lines of a two-wire serial bus without driving them. It samples both lines on a fast system clock and passes each line through a two-flop synchronizer and a spike filter. It then finds clock edges and the bus conditions on the cleaned lines. A start is the data line falling while the clock line is high. A stop is the data line rising while the clock line is high. Any data-line change while the clock is high counts as one of these two conditions and never as data.

The monitor keeps a set of saturating interval counters and compares each measured interval with the minimum allowed for the selected speed grade. The grade is either slow (100 kHz) or fast (400 kHz). Every limit is stored as a cycle count derived from the `CLK_HZ` parameter and rounded up. Each class of violation has its own one-cycle pulse and its own sticky flag. A flag stays set until `clr_i` or reset. The lines carry no data stream, so the block has no valid/ready interface, and all of its pins are plain control and status signals.

Top module: `twb_timing_mon`

## Requirements
- R1: A pulse on either bus line shorter than 100 ns (with `fast_i`=0) or 50 ns (with `fast_i`=1) is discarded and causes no edge. A pulse at least that long is taken as two edges.
- R2: Bit 0 reports a clock-low time shorter than 4.7 µs (slow) or 1.2 µs (fast), measured from a clock fall to the next clock rise.
- R3: Bit 1 reports a clock-high time shorter than 4.0 µs (slow) or 0.6 µs (fast), measured from a clock rise to the next clock fall.
- R4: Bit 2 reports a start whose following clock fall comes less than 4.0 µs (slow) or 0.6 µs (fast) after it. A start is the data line falling while the clock line is high.
- R5: Bit 3 reports a start that comes less than 4.7 µs (slow) or 0.6 µs (fast) after the latest clock rise. This is the repeated-start setup check.
- R6: Bit 4 reports a clock rise that comes less than 200 ns (slow) or 100 ns (fast) after the latest data-line change.
- R7: Bit 5 reports a stop that comes less than 4.7 µs (slow) or 0.6 µs (fast) after the latest clock rise. A stop is the data line rising while the clock line is high.
- R8: Bit 6 reports a start that comes less than 4.7 µs (slow) or 1.2 µs (fast) after the latest stop.
- R9: Each limit is held as ceil(time × `CLK_HZ`) cycles. An interval exactly equal to that count raises no flag, and an interval one cycle shorter raises the flag.
- R10: Each violating event gives a pulse of exactly one cycle on its bit of `err_pulse_o`. The matching bit of `err_flag_o` then stays set until `clr_i` is high. A violation in the same cycle as a clear keeps its bit set.
- R11: Reset clears every flag and pulse and puts the filtered lines in the idle-high state. The first edges after reset raise no violation, because no earlier reference event exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_i | input | 1 | Synchronous active-high reset |
| fast_i | input | 1 | Speed grade: 0 = slow limits, 1 = fast limits |
| clr_i | input | 1 | Clears all sticky flags |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| err_flag_o | output | 7 | Sticky violation flags, bit map as in R2–R8 |
| err_pulse_o | output | 7 | One-cycle violation pulses, same bit map |

## Verification
Assertions check on every cycle that the spike filter only takes a value the synchronized line has shown, and that interval counters hold at saturation rather than wrap. They also check that every pulse lands in its sticky flag, that flags never drop without a clear, and that a clear leaves exactly the same-cycle pulses set. A low-time pulse must also follow a filtered clock rise. Only the bench scenarios can show the numeric limits of both grades, the exact pass at the limit and the fail one cycle below it, and the filter threshold on real pulses. They also cover the repeated-start check and the absence of false violations after reset.

// File: rtl/twb_mon_pkg.sv
package twb_mon_pkg;

  localparam int NCHK = 7;

  // violation bit positions, fixed by the port map
  localparam int E_LOW   = 0;
  localparam int E_HIGH  = 1;
  localparam int E_HDSTA = 2;
  localparam int E_SUSTA = 3;
  localparam int E_SUDAT = 4;
  localparam int E_SUSTO = 5;
  localparam int E_BUF   = 6;

  // interval counter indices
  localparam int NCNT    = 5;
  localparam int C_FALL  = 0;
  localparam int C_RISE  = 1;
  localparam int C_SDA   = 2;
  localparam int C_START = 3;
  localparam int C_STOP  = 4;

  // nanoseconds to clock cycles, rounded up, at least one
  function automatic int ns2cyc(input int ns, input int hz);
    longint prod;
    longint cyc;
    prod = longint'(ns) * longint'(hz);
    cyc  = (prod + 64'sd999_999_999) / 64'sd1_000_000_000;
    if (cyc < 1) cyc = 1;
    return int'(cyc);
  endfunction

endpackage

// File: rtl/twb_line_cond.sv
module twb_line_cond #(
  parameter int FILT_SLOW = 10,
  parameter int FILT_FAST = 5
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic fast_i,
  input  logic raw_i,
  output logic filt_o
);
  localparam int FW = $clog2(FILT_SLOW + 1);

  logic          s1_q, s2_q, filt_q;
  logic [FW-1:0] run_q;
  logic [FW-1:0] run_lim;

  assign run_lim = fast_i ? FW'(FILT_FAST - 1) : FW'(FILT_SLOW - 1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      filt_q <= 1'b1;
      run_q  <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      if (s2_q != filt_q) begin
        if (run_q >= run_lim) begin
          filt_q <= s2_q;
          run_q  <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign filt_o = filt_q;

  assert_filter_follow_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    (filt_q != $past(filt_q)) |-> ($past(s2_q) == filt_q));

endmodule

// File: rtl/twb_sat_cnt.sv
module twb_sat_cnt #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         restart_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)               cnt_q <= '1;
    else if (restart_i)      cnt_q <= W'(1);
    else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_cnt_no_wrap_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(cnt_q) == '1 && !$past(restart_i)) |-> (cnt_q == '1));

endmodule

// File: rtl/twb_evt_det.sv
module twb_evt_det (
  input  logic clk_i,
  input  logic rst_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic sda_edge_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign sda_edge_o = sda_i ^ sda_q;
  // a data change with the clock high before and after is a bus condition
  assign start_o    = sda_q & ~sda_i & scl_q & scl_i;
  assign stop_o     = ~sda_q & sda_i & scl_q & scl_i;

endmodule

// File: rtl/twb_interval_chk.sv
module twb_interval_chk
  import twb_mon_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000,
  parameter int CW     = 10
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            fast_i,
  input  logic            clr_i,
  input  logic            scl_rise_i,
  input  logic            scl_fall_i,
  input  logic            sda_edge_i,
  input  logic            start_i,
  input  logic            stop_i,
  output logic [NCHK-1:0] err_flag_o,
  output logic [NCHK-1:0] err_pulse_o
);
  localparam int LIM_S [NCHK] = '{
    ns2cyc(4700, CLK_HZ), ns2cyc(4000, CLK_HZ), ns2cyc(4000, CLK_HZ),
    ns2cyc(4700, CLK_HZ), ns2cyc(200,  CLK_HZ), ns2cyc(4700, CLK_HZ),
    ns2cyc(4700, CLK_HZ)};
  localparam int LIM_F [NCHK] = '{
    ns2cyc(1200, CLK_HZ), ns2cyc(600,  CLK_HZ), ns2cyc(600,  CLK_HZ),
    ns2cyc(600,  CLK_HZ), ns2cyc(100,  CLK_HZ), ns2cyc(600,  CLK_HZ),
    ns2cyc(1200, CLK_HZ)};

  logic [NCNT-1:0] restart;
  logic [CW-1:0]   cnt [NCNT];
  logic [CW-1:0]   lim [NCHK];
  logic [NCHK-1:0] viol;
  logic [NCHK-1:0] flag_q, pulse_q;
  logic            start_pend_q;

  assign restart[C_FALL]  = scl_fall_i;
  assign restart[C_RISE]  = scl_rise_i;
  assign restart[C_SDA]   = sda_edge_i;
  assign restart[C_START] = start_i;
  assign restart[C_STOP]  = stop_i;

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    twb_sat_cnt #(.W(CW)) cnt_i (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .restart_i (restart[g]),
      .cnt_o     (cnt[g])
    );
  end

  always_comb begin
    for (int i = 0; i < NCHK; i++) begin
      lim[i] = fast_i ? CW'(LIM_F[i]) : CW'(LIM_S[i]);
    end
  end

  always_comb begin
    viol          = '0;
    viol[E_LOW]   = scl_rise_i & (cnt[C_FALL] < lim[E_LOW]);
    viol[E_HIGH]  = scl_fall_i & (cnt[C_RISE] < lim[E_HIGH]);
    viol[E_HDSTA] = scl_fall_i & start_pend_q & (cnt[C_START] < lim[E_HDSTA]);
    viol[E_SUSTA] = start_i & (cnt[C_RISE] < lim[E_SUSTA]);
    viol[E_SUDAT] = scl_rise_i & (cnt[C_SDA] < lim[E_SUDAT]);
    viol[E_SUSTO] = stop_i & (cnt[C_RISE] < lim[E_SUSTO]);
    viol[E_BUF]   = start_i & (cnt[C_STOP] < lim[E_BUF]);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      flag_q       <= '0;
      pulse_q      <= '0;
      start_pend_q <= 1'b0;
    end else begin
      pulse_q <= viol;
      flag_q  <= (clr_i ? '0 : flag_q) | viol;
      if (start_i)                  start_pend_q <= 1'b1;
      else if (scl_fall_i | stop_i) start_pend_q <= 1'b0;
    end
  end

  assign err_flag_o  = flag_q;
  assign err_pulse_o = pulse_q;

  assert_pulse_lands_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (err_pulse_o != '0) |=> ((err_flag_o & $past(err_pulse_o)) == $past(err_pulse_o)));

  assert_flag_sticky_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    !clr_i |=> ((err_flag_o & $past(err_flag_o)) == $past(err_flag_o)));

  assert_clear_leaves_pulses_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_i |=> (err_flag_o == err_pulse_o));

  assert_low_after_rise_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    err_pulse_o[E_LOW] |-> $past(scl_rise_i));

endmodule

// File: rtl/twb_timing_mon.sv
module twb_timing_mon
  import twb_mon_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            fast_i,
  input  logic            clr_i,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic [NCHK-1:0] err_flag_o,
  output logic [NCHK-1:0] err_pulse_o
);
  localparam int FILT_SLOW = ns2cyc(100, CLK_HZ);
  localparam int FILT_FAST = ns2cyc(50, CLK_HZ);
  localparam int CW        = $clog2(ns2cyc(4700, CLK_HZ) + 1) + 1;

  logic [1:0] raw, filt;
  logic scl_rise, scl_fall, sda_edge, start, stop;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    twb_line_cond #(.FILT_SLOW(FILT_SLOW), .FILT_FAST(FILT_FAST)) cond_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .fast_i (fast_i),
      .raw_i  (raw[g]),
      .filt_o (filt[g])
    );
  end

  twb_evt_det evt_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .scl_i      (filt[0]),
    .sda_i      (filt[1]),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .sda_edge_o (sda_edge),
    .start_o    (start),
    .stop_o     (stop)
  );

  twb_interval_chk #(.CLK_HZ(CLK_HZ), .CW(CW)) chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .fast_i      (fast_i),
    .clr_i       (clr_i),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .sda_edge_i  (sda_edge),
    .start_i     (start),
    .stop_i      (stop),
    .err_flag_o  (err_flag_o),
    .err_pulse_o (err_pulse_o)
  );

endmodule

// File: tb/twb_timing_mon_tb.sv
`timescale 1ns/1ps
module twb_timing_mon_tb_top;

  typedef struct packed {
    logic [31:0] tag;
    logic        fast;
    logic [15:0] lo, hi, hd, sd, so, bf;
    logic [6:0]  mask;
  } vec_t;

  // limits at 100 MHz, slow/fast: low 470/120, high 400/60, start hold 400/60,
  // data setup 20/10, stop setup 470/60, bus free 470/120
  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{"R9  ", 1'b0, 16'd470, 16'd400, 16'd400, 16'd20, 16'd470, 16'd470, 7'h00}, // R9 exact slow
    '{"R11 ", 1'b0, 16'd600, 16'd500, 16'd500, 16'd50, 16'd600, 16'd600, 7'h00}, // margin slow
    '{"R2  ", 1'b0, 16'd469, 16'd400, 16'd400, 16'd20, 16'd470, 16'd470, 7'h01}, // R2 low short
    '{"R3  ", 1'b0, 16'd470, 16'd399, 16'd400, 16'd20, 16'd470, 16'd470, 7'h02}, // R3 high short
    '{"R4  ", 1'b0, 16'd470, 16'd400, 16'd399, 16'd20, 16'd470, 16'd470, 7'h04}, // R4 hold short
    '{"R6  ", 1'b0, 16'd470, 16'd400, 16'd400, 16'd19, 16'd470, 16'd470, 7'h10}, // R6 data setup
    '{"R7  ", 1'b0, 16'd470, 16'd400, 16'd400, 16'd20, 16'd469, 16'd470, 7'h20}, // R7 stop setup
    '{"R8  ", 1'b0, 16'd470, 16'd400, 16'd400, 16'd20, 16'd470, 16'd469, 7'h40}, // R8 bus free
    '{"R9  ", 1'b1, 16'd120, 16'd60,  16'd60,  16'd10, 16'd60,  16'd120, 7'h00}, // R9 exact fast
    '{"R2  ", 1'b1, 16'd119, 16'd60,  16'd60,  16'd10, 16'd60,  16'd120, 7'h01},
    '{"R3  ", 1'b1, 16'd120, 16'd59,  16'd60,  16'd10, 16'd60,  16'd120, 7'h02},
    '{"R4  ", 1'b1, 16'd120, 16'd60,  16'd59,  16'd10, 16'd60,  16'd120, 7'h04},
    '{"R6  ", 1'b1, 16'd120, 16'd60,  16'd60,  16'd9,  16'd60,  16'd120, 7'h10},
    '{"R7  ", 1'b1, 16'd120, 16'd60,  16'd60,  16'd10, 16'd59,  16'd120, 7'h20},
    '{"R8  ", 1'b1, 16'd120, 16'd60,  16'd60,  16'd10, 16'd60,  16'd119, 7'h40},
    '{"R5  ", 1'b0, 16'd120, 16'd60,  16'd60,  16'd10, 16'd60,  16'd120, 7'h7F}, // R5 all, slow grade
    '{"R9  ", 1'b1, 16'd470, 16'd400, 16'd400, 16'd20, 16'd470, 16'd470, 7'h00}  // slow timing, fast grade
  };

  logic clk = 1'b0, rst = 1'b1, fast = 1'b0, clr = 1'b0, scl = 1'b1, sda = 1'b1;
  logic [6:0] err_flag, err_pulse;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int pcyc [7];
  int prise [7];
  logic [6:0] pprev = '0;

  always #5 clk = ~clk;

  twb_timing_mon dut_i (
    .clk_i(clk), .rst_i(rst), .fast_i(fast), .clr_i(clr),
    .scl_i(scl), .sda_i(sda), .err_flag_o(err_flag), .err_pulse_o(err_pulse)
  );

  initial for (int b = 0; b < 7; b++) begin pcyc[b] = 0; prise[b] = 0; end

  always @(negedge clk) begin
    for (int b = 0; b < 7; b++) begin
      if (err_pulse[b]) pcyc[b] = pcyc[b] + 1;
      if (err_pulse[b] && !pprev[b]) prise[b] = prise[b] + 1;
    end
    pprev = err_pulse;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_flags();
    clr = 1'b1; cyc(1); clr = 1'b0; cyc(1);
  endtask

  task automatic frame(input vec_t v);
    fast = v.fast;
    sda = 1'b0; cyc(int'(v.hd));                    // start
    scl = 1'b0; cyc(int'(v.lo) - int'(v.sd));
    sda = 1'b1; cyc(int'(v.sd));
    scl = 1'b1; cyc(int'(v.hi));
    scl = 1'b0; cyc(2);
    sda = 1'b0; cyc(int'(v.lo) - 2);
    scl = 1'b1; cyc(int'(v.so));
    sda = 1'b1; cyc(int'(v.bf));                    // stop, then idle
    sda = 1'b0; cyc(int'(v.hd));                    // second start
    scl = 1'b0; cyc(int'(v.lo));
    scl = 1'b1; cyc(int'(v.so));
    sda = 1'b1; cyc(500);                           // stop and settle
  endtask

  // start from idle with legal timing, one clock bit, stop
  task automatic tail();
    sda = 1'b0; cyc(400);
    scl = 1'b0; cyc(470);
    scl = 1'b1; cyc(470);
    sda = 1'b1; cyc(500);
  endtask

  task automatic glitch(input logic f, input int len, input int exp, input string req);
    fast = f;
    sda = 1'b0; cyc(len);
    sda = 1'b1; cyc(100);
    tail();
    chk(req, int'(err_flag), exp);
    clear_flags();
  endtask

  task automatic rep_start(input int t, input int exp);
    fast = 1'b0;
    sda = 1'b0; cyc(400);
    scl = 1'b0; cyc(100);
    sda = 1'b1; cyc(370);
    scl = 1'b1; cyc(t);
    sda = 1'b0; cyc(400);                           // repeated start
    scl = 1'b0; cyc(470);
    scl = 1'b1; cyc(470);
    sda = 1'b1; cyc(500);
    chk("R5 repeated start setup", int'(err_flag), exp);
    clear_flags();
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cyc(5);
    chk("R11 reset flags", int'(err_flag), 0);
    chk("R11 reset pulses", int'(err_pulse), 0);
    rst = 1'b0;
    cyc(20);
    chk("R11 idle after reset", int'(err_flag), 0);

    // vector table: R2..R9
    for (int i = 0; i < NV; i++) begin
      frame(TBL[i]);
      chk($sformatf("%s table row %0d", TBL[i].tag, i), int'(err_flag), int'(TBL[i].mask));
      clear_flags();
      chk($sformatf("R10 clear after row %0d", i), int'(err_flag), 0);
    end

    // R1: filter threshold per grade, observed through bus-free check
    glitch(1'b0, 9,  0,    "R1 slow 90ns glitch ignored");
    glitch(1'b0, 10, 7'h40, "R1 slow 100ns pulse taken");
    glitch(1'b1, 4,  0,    "R1 fast 40ns glitch ignored");
    glitch(1'b1, 5,  7'h40, "R1 fast 50ns pulse taken");

    // R5: repeated start setup boundary
    rep_start(469, 7'h08);
    rep_start(470, 7'h00);

    // R10: one-cycle pulses and stickiness
    for (int b = 0; b < 7; b++) begin pcyc[b] = 0; prise[b] = 0; end
    frame(TBL[4]);
    chk("R10 hold pulse cycles", pcyc[2], 2);
    chk("R10 hold pulse count", prise[2], 2);
    cyc(300);
    chk("R10 flag sticky", int'(err_flag), 7'h04);
    clear_flags();
    chk("R10 flag cleared", int'(err_flag), 0);

    // R11: reset clears a set flag, first edges after reset clean
    frame(TBL[2]);
    chk("R11 flag before reset", int'(err_flag), 7'h01);
    rst = 1'b1; cyc(3);
    chk("R11 reset clears flag", int'(err_flag), 0);
    rst = 1'b0; cyc(3);
    frame(TBL[0]);
    chk("R11 clean frame after reset", int'(err_flag), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule